// File: doc/BRIEF.md
# Diagnostic Progress Port Router

This block decodes I/O cycles aimed at the legacy diagnostic progress-code port group and steers them downstream. A write to one of the eight decoded ports goes to exactly one of two downstream interfaces, LPC or PCI, as a single-cycle strobe. A route-select input chooses the interface. Every such write is also captured in a local shadow byte. Reads of the decoded ports are never sent downstream; the block answers them from its shadow.

Each interface has its own shadow bank. A write updates only the bank of the interface it was sent to. A read returns the byte from the bank that the route input currently selects. After the route input changes, reads therefore show what was last written through the newly selected interface. A second group of eight alias ports sits 10h above the first. Aliases always go to LPC, for both reads and writes, and never touch either shadow bank.

All forward strobes, addresses and data, and the read-data response appear one clock after the request. The claim output is combinational in the request cycle.

Top module: `postcode_router`

## Requirements
- R1: `ioClaim` is high in the request cycle exactly when `ioWr` or `ioRd` is high and `ioAddr` is one of 0080h, 0084h, 0085h, 0086h, 0088h, 008Ch, 008Dh, 008Eh (decoded ports) or 0090h, 0094h, 0095h, 0096h, 0098h, 009Ch, 009Dh, 009Eh (aliases); every other 16-bit address is unclaimed.
- R2: With `routePci` = 0, a write to a decoded port gives one cycle later a one-cycle `lpcWrStb` with `lpcAddr`/`lpcData` equal to the request, no `pciWrStb`, and stores the byte in the LPC shadow bank.
- R3: With `routePci` = 1, a write to a decoded port gives one cycle later a one-cycle `pciWrStb` with `pciAddr`/`pciData` equal to the request, no `lpcWrStb`, and stores the byte in the PCI shadow bank.
- R4: A read of a decoded port raises no forward strobe; one cycle later `rdValid` pulses with `rdData` equal to that port's byte in the bank selected by `routePci` during the read.
- R5: The banks are independent: after the route input changes, reads return the other bank's bytes and not the last value written.
- R6: A write to an alias port gives a one-cycle `lpcWrStb` with its address and data one cycle later, whatever `routePci` is, and changes neither shadow bank.
- R7: A read of an alias port gives a one-cycle `lpcRdStb` with `lpcAddr` equal to the alias one cycle later, whatever `routePci` is, and no `rdValid`.
- R8: After reset all strobes and `rdValid` are low and every byte of both banks reads 00h.
- R9: When `ioWr` and `ioRd` are high in the same cycle, only the write is carried out.
- R10: An unclaimed access raises no strobe, no `rdValid`, and changes no shadow byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the request |
| ioWdata | input | 8 | Write data |
| ioWr | input | 1 | Write request, one cycle per access |
| ioRd | input | 1 | Read request, one cycle per access |
| routePci | input | 1 | Route select: 0 = LPC, 1 = PCI |
| ioClaim | output | 1 | Request claimed by this block (combinational) |
| rdValid | output | 1 | Read response valid, one cycle |
| rdData | output | 8 | Shadow byte for the read |
| lpcWrStb | output | 1 | Write strobe toward LPC |
| lpcRdStb | output | 1 | Read strobe toward LPC (aliases only) |
| lpcAddr | output | 16 | Address toward LPC |
| lpcData | output | 8 | Write data toward LPC |
| pciWrStb | output | 1 | Write strobe toward PCI |
| pciAddr | output | 16 | Address toward PCI |
| pciData | output | 8 | Write data toward PCI |

## Verification
The bench fills both banks with different patterns. It then flips the route input and reads every port. A design with one shared bank, or one that picks the bank from the write history, returns the wrong byte here. Alias writes and reads are sent under both route settings and followed by readback of every decoded port. This catches a design that routes aliases by the route input or lets them update a shadow. Near-miss addresses (0081h, 008Fh, 009Fh, 00A0h, 1080h) expose an over-wide nibble or upper-bit compare. A simultaneous write and read exposes a design that answers a read while also writing.

// File: rtl/postcode_router_pkg.sv
package postcode_router_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef struct packed {
    logic              lpcWr;
    logic              lpcRd;
    logic              pciWr;
    logic              shadowWr;
    logic              shadowRd;
    logic              bankPci;
    logic [SLOT_W-1:0] slot;
  } ctrlStb_t;
endpackage

// File: rtl/postcode_router_ctrl.sv
module postcode_router_ctrl
  import postcode_router_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_BASE  = 16'h0080,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'h0090
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              routePci,
  output ctrlStb_t          stb,
  output logic              ioClaim
);
  localparam logic [3:0] SLOT_OFFS [NUM_SLOTS] =
    '{4'h0, 4'h4, 4'h5, 4'h6, 4'h8, 4'hC, 4'hD, 4'hE};

  logic              nibHit;
  logic [SLOT_W-1:0] slotIdx;
  logic              portHit, aliasHit, rdOnly;

  always_comb begin
    nibHit  = 1'b0;
    slotIdx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (ioAddr[3:0] == SLOT_OFFS[i]) begin
        nibHit  = 1'b1;
        slotIdx = SLOT_W'(i);
      end
    end
  end

  assign portHit  = nibHit && (ioAddr[ADDR_W-1:4] == PORT_BASE[ADDR_W-1:4]);
  assign aliasHit = nibHit && (ioAddr[ADDR_W-1:4] == ALIAS_BASE[ADDR_W-1:4]);
  assign rdOnly   = ioRd && !ioWr;

  always_comb begin
    stb.lpcWr    = ioWr && (aliasHit || (portHit && !routePci));
    stb.pciWr    = ioWr && portHit && routePci;
    stb.lpcRd    = rdOnly && aliasHit;
    stb.shadowWr = ioWr && portHit;
    stb.shadowRd = rdOnly && portHit;
    stb.bankPci  = routePci;
    stb.slot     = slotIdx;
  end

  assign ioClaim = (ioWr || ioRd) && (portHit || aliasHit);
endmodule

// File: rtl/postcode_router_dp.sv
module postcode_router_dp
  import postcode_router_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_BASE = 16'h0080
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              lpcWrStb,
  output logic              lpcRdStb,
  output logic [ADDR_W-1:0] lpcAddr,
  output logic [DATA_W-1:0] lpcData,
  output logic              pciWrStb,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [DATA_W-1:0] pciData
);
  localparam int NUM_BANKS = 2;

  logic [DATA_W-1:0] bankRd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [DATA_W-1:0] mem [NUM_SLOTS];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int s = 0; s < NUM_SLOTS; s++) mem[s] <= '0;
      end else if (stb.shadowWr && (stb.bankPci == b[0])) begin
        mem[stb.slot] <= ioWdata;
      end
    end
    assign bankRd[b] = mem[stb.slot];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      rdData   <= '0;
      lpcWrStb <= 1'b0;
      lpcRdStb <= 1'b0;
      lpcAddr  <= '0;
      lpcData  <= '0;
      pciWrStb <= 1'b0;
      pciAddr  <= '0;
      pciData  <= '0;
    end else begin
      rdValid  <= stb.shadowRd;
      lpcWrStb <= stb.lpcWr;
      lpcRdStb <= stb.lpcRd;
      pciWrStb <= stb.pciWr;
      if (stb.shadowRd) rdData <= bankRd[stb.bankPci];
      if (stb.lpcWr || stb.lpcRd) begin
        lpcAddr <= ioAddr;
        lpcData <= ioWdata;
      end
      if (stb.pciWr) begin
        pciAddr <= ioAddr;
        pciData <= ioWdata;
      end
    end
  end

  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lpcWrStb, lpcRdStb, pciWrStb, rdValid})) else $error("two actions at once"); // R2
  AST_PCI_PORT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    pciWrStb |-> (pciAddr[ADDR_W-1:4] == PORT_BASE[ADDR_W-1:4])) else $error("pci got non-port"); // R3
endmodule

// File: rtl/postcode_router.sv
module postcode_router
  import postcode_router_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_BASE  = 16'h0080,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'h0090
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              routePci,
  output logic              ioClaim,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              lpcWrStb,
  output logic              lpcRdStb,
  output logic [ADDR_W-1:0] lpcAddr,
  output logic [DATA_W-1:0] lpcData,
  output logic              pciWrStb,
  output logic [ADDR_W-1:0] pciAddr,
  output logic [DATA_W-1:0] pciData
);
  ctrlStb_t stb;

  postcode_router_ctrl #(
    .ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) ctrl_i (
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd), .routePci(routePci),
    .stb(stb), .ioClaim(ioClaim)
  );

  postcode_router_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_BASE(PORT_BASE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .ioAddr(ioAddr), .ioWdata(ioWdata),
    .rdValid(rdValid), .rdData(rdData),
    .lpcWrStb(lpcWrStb), .lpcRdStb(lpcRdStb), .lpcAddr(lpcAddr), .lpcData(lpcData),
    .pciWrStb(pciWrStb), .pciAddr(pciAddr), .pciData(pciData)
  );

  AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((ioWr || ioRd) && !ioClaim) |=> !(lpcWrStb || lpcRdStb || pciWrStb || rdValid)) else $error("unclaimed acted"); // R10
  AST_ALIAS_TO_LPC: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && ioClaim && (ioAddr[ADDR_W-1:4] == ALIAS_BASE[ADDR_W-1:4])) |=> (lpcWrStb && !pciWrStb)) else $error("alias misrouted"); // R6
  AST_READ_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !ioWr && ioClaim && (ioAddr[ADDR_W-1:4] == PORT_BASE[ADDR_W-1:4])) |=> (rdValid && !lpcRdStb)) else $error("port read forwarded"); // R4
endmodule

// File: tb/postcode_router_tb.sv
module postcode_router_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWdata = '0;
  logic        ioWr = 1'b0, ioRd = 1'b0, routePci = 1'b0;
  logic        ioClaim, rdValid, lpcWrStb, lpcRdStb, pciWrStb;
  logic [7:0]  rdData, lpcData, pciData;
  logic [15:0] lpcAddr, pciAddr;

  int nTests = 0, nFail = 0;
  bit done = 0;
  int shL [8];
  int shP [8];

  always #5 clk = ~clk;

  postcode_router dut_i (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWdata(ioWdata), .ioWr(ioWr), .ioRd(ioRd),
    .routePci(routePci), .ioClaim(ioClaim), .rdValid(rdValid), .rdData(rdData),
    .lpcWrStb(lpcWrStb), .lpcRdStb(lpcRdStb), .lpcAddr(lpcAddr), .lpcData(lpcData),
    .pciWrStb(pciWrStb), .pciAddr(pciAddr), .pciData(pciData)
  );

  function automatic int slotOf(input logic [15:0] a);
    case (a[3:0])
      4'h0: return 0; 4'h4: return 1; 4'h5: return 2; 4'h6: return 3;
      4'h8: return 4; 4'hC: return 5; 4'hD: return 6; 4'hE: return 7;
      default: return -1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [15:0] a,
                      input logic [7:0] d, input logic rt, input string tag);
    int s;
    bit isPort, isAlias, eClaim, eLW, eLR, ePW, eRV;
    int eRd;
    ioWr = wr; ioRd = rd; ioAddr = a; ioWdata = d; routePci = rt;
    s = slotOf(a);
    isPort  = (s >= 0) && (a[15:4] == 12'h008);
    isAlias = (s >= 0) && (a[15:4] == 12'h009);
    eClaim = (wr || rd) && (isPort || isAlias);
    #1;
    chk(ioClaim == eClaim, "R1", "claim", ioClaim, eClaim);
    eLW = wr && (isAlias || (isPort && !rt));
    ePW = wr && isPort && rt;
    eLR = !wr && rd && isAlias;
    eRV = !wr && rd && isPort;
    eRd = 0;
    if (eRV) eRd = rt ? shP[s] : shL[s];
    if (wr && isPort) begin
      if (rt) shP[s] = d; else shL[s] = d;
    end
    @(negedge clk);
    chk(lpcWrStb == eLW, tag, "lpcWrStb", lpcWrStb, eLW);
    chk(pciWrStb == ePW, tag, "pciWrStb", pciWrStb, ePW);
    chk(lpcRdStb == eLR, tag, "lpcRdStb", lpcRdStb, eLR);
    chk(rdValid == eRV, tag, "rdValid", rdValid, eRV);
    if (eLW || eLR) chk(lpcAddr == a, tag, "lpcAddr", lpcAddr, a);
    if (eLW) chk(lpcData == d, tag, "lpcData", lpcData, d);
    if (ePW) begin
      chk(pciAddr == a, tag, "pciAddr", pciAddr, a);
      chk(pciData == d, tag, "pciData", pciData, d);
    end
    if (eRV) chk(rdData == eRd[7:0], tag, "rdData", rdData, eRd);
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  function automatic logic [15:0] portAddr(input int i, input logic [15:0] base);
    logic [3:0] offs [8] = '{4'h0, 4'h4, 4'h5, 4'h6, 4'h8, 4'hC, 4'hD, 4'hE};
    return base | 16'(offs[i]);
  endfunction

  task automatic readAll(input logic rt, input string tag);
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, portAddr(i, 16'h0080), 8'h00, rt, tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin shL[i] = 0; shP[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8: outputs idle after reset
    chk(!(lpcWrStb || lpcRdStb || pciWrStb || rdValid), "R8", "strobes after reset",
        {lpcWrStb, lpcRdStb, pciWrStb, rdValid}, 0);
    readAll(1'b0, "R8");
    readAll(1'b1, "R8");
    // R2: LPC route writes
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, portAddr(i, 16'h0080), 8'(8'h10 + i), 1'b0, "R2");
    readAll(1'b0, "R4");
    // R5: other bank still empty
    readAll(1'b1, "R5");
    // R3: PCI route writes
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, portAddr(i, 16'h0080), 8'(8'hA0 + i), 1'b1, "R3");
    readAll(1'b1, "R4");
    readAll(1'b0, "R5");
    // R6: alias writes under both routes, then banks unchanged
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, portAddr(i, 16'h0090), 8'(8'h5C + i), 1'(i % 2), "R6");
    readAll(1'b0, "R6");
    readAll(1'b1, "R6");
    // R7: alias reads
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, portAddr(i, 16'h0090), 8'h00, 1'(i / 4), "R7");
    // R10: near-miss addresses
    step(1'b1, 1'b0, 16'h0081, 8'hEE, 1'b0, "R10");
    step(1'b1, 1'b0, 16'h008F, 8'hEE, 1'b1, "R10");
    step(1'b1, 1'b0, 16'h009F, 8'hEE, 1'b0, "R10");
    step(1'b1, 1'b0, 16'h00A0, 8'hEE, 1'b0, "R10");
    step(1'b1, 1'b0, 16'h1080, 8'hEE, 1'b0, "R10");
    step(1'b0, 1'b1, 16'h1084, 8'h00, 1'b1, "R10");
    step(1'b0, 1'b1, 16'h0091, 8'h00, 1'b0, "R10");
    readAll(1'b0, "R10");
    // R9: write and read together
    step(1'b1, 1'b1, 16'h0084, 8'h5A, 1'b0, "R9");
    step(1'b1, 1'b1, 16'h0094, 8'h3C, 1'b1, "R9");
    readAll(1'b0, "R9");
    readAll(1'b1, "R9");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule